// File: doc/BRIEF.md
# Serial Integrating ADC Controller

This block sequences a single-comparator integrating converter that digitises the difference between a positive and a negative analog rail. A conversion starts with one bare comparison. That comparison fixes the output sign and selects which rail is the lower one. The controller then issues charge-share step strobes to the lower rail. Each step is followed by a settle interval, a comparator enable pulse and a decision sample. Integration stops as soon as the corrected decision reverses, so short codes finish in few cycles. This suits inputs whose values are mostly small.

The comparator inputs pass through a swap selector that the controller flips after every completed conversion. This cancels comparator offset over pairs of conversions. The raw decision bit is therefore re-interpreted according to the current swap state. The signed result is a sign bit over a six-bit step count, and a one-cycle valid strobe accompanies it.

Top module: `serial_adc_ctrl`

## Requirements
- R1: After reset, the following outputs are all low: busy_o, valid_o, cmp_en_o, share_o and swap_o. result_o is zero.
- R2: The corrected decision is cmp_i XOR swap_o. A corrected 1 means the positive rail is at or above the negative rail. result_o[6] is the sign: 0 means positive and 1 means negative. The sign equals the inverse of the first corrected decision of the conversion, except as stated in R8.
- R3: int_neg_o is high, selecting integration of the negative rail, when the first corrected decision is 1. It is low otherwise. It holds this value for the rest of the conversion.
- R4: A start_i pulse in idle produces one cmp_en_o cycle with no preceding share_o. Each step after that is one share_o cycle, SETTLE_CYC settle cycles, one cmp_en_o cycle and one sample cycle. share_o and cmp_en_o are never high together.
- R5: Integration ends at the first step whose corrected decision differs from the first decision. After that step, no further share_o or cmp_en_o pulses are issued. result_o[5:0] equals the number of steps that completed without a reversal.
- R6: If 63 steps complete without a reversal, the conversion ends with magnitude 63.
- R7: swap_o toggles exactly once per completed conversion, on the same edge that raises valid_o. It is stable otherwise.
- R8: A zero magnitude is always reported with the sign bit at 0.
- R9: valid_o is high for exactly one cycle per conversion. result_o carries the new result in that cycle and holds it until the next conversion completes.
- R10: start_i is ignored while busy_o is high. It neither restarts nor extends the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a conversion (honoured when idle) |
| cmp_i | input | 1 | Raw comparator decision, sampled the cycle after cmp_en_o |
| cmp_en_o | output | 1 | Comparator enable pulse |
| share_o | output | 1 | Charge-share step strobe |
| int_neg_o | output | 1 | 1: negative rail integrates, 0: positive rail integrates |
| swap_o | output | 1 | Comparator input swap selector |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe with a new result |
| result_o | output | 7 | Sign (bit 6) and magnitude (bits 5:0) |

## Verification
The assertions assume that cmp_i is valid and stable in the cycle after each cmp_en_o pulse. They also assume start_i is a clean synchronous level. The bench drives a comparator model that updates cmp_i only on the falling edge after an enable pulse. The model derives its decision from a signed rail difference plus the number of strobes it has counted, then inverts it while its own swap tracker is set. The model never touches cmp_i at other times, so the decision the design samples always reflects the step just completed.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SGN_EN,
    ST_SGN_RD,
    ST_SHARE,
    ST_SETTLE,
    ST_CMP_EN,
    ST_CMP_RD
  } sadc_state_e;
endpackage

// File: rtl/sadc_polarity.sv
module sadc_polarity (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmp_raw_i,
  input  logic toggle_i,
  output logic swap_o,
  output logic dec_o
);
  logic swap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       swap_q <= 1'b0;
    else if (toggle_i) swap_q <= ~swap_q;
  end

  // swapped inputs invert the raw polarity
  assign dec_o  = cmp_raw_i ^ swap_q;
  assign swap_o = swap_q;
endmodule

// File: rtl/sadc_step_cnt.sv
module sadc_step_cnt #(
  parameter int MAG_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [MAG_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [MAG_W-1:0] LastVal = MAG_W'((2 ** MAG_W) - 2);

  logic [MAG_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == LastVal);
endmodule

// File: rtl/sadc_fsm.sv
module sadc_fsm
  import sadc_pkg::*;
#(
  parameter int MAG_W      = 6,
  parameter int SETTLE_CYC = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             dec_i,
  input  logic [MAG_W-1:0] cnt_i,
  input  logic             cnt_last_i,
  output logic             cnt_clr_o,
  output logic             cnt_inc_o,
  output logic             toggle_o,
  output logic             cmp_en_o,
  output logic             share_o,
  output logic             busy_o,
  output logic             int_neg_o,
  output logic             valid_o,
  output logic [MAG_W:0]   result_o
);
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [SW-1:0]    SettleLast = SW'(SETTLE_CYC - 1);
  localparam logic [MAG_W-1:0] MagMax     = '1;

  sadc_state_e state_q, state_d;
  logic [SW-1:0]    settle_q;
  logic             pos_q;
  logic             valid_q;
  logic [MAG_W:0]   result_q;
  logic             finish;
  logic             flip;
  logic [MAG_W-1:0] mag;

  assign flip = (dec_i != pos_q);
  assign mag  = flip ? cnt_i : MagMax;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_inc_o = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (start_i) begin
                   state_d   = ST_SGN_EN;
                   cnt_clr_o = 1'b1;
                 end
      ST_SGN_EN: state_d = ST_SGN_RD;
      ST_SGN_RD: state_d = ST_SHARE;
      ST_SHARE:  state_d = ST_SETTLE;
      ST_SETTLE: if (settle_q == SettleLast) state_d = ST_CMP_EN;
      ST_CMP_EN: state_d = ST_CMP_RD;
      ST_CMP_RD: begin
        if (flip || cnt_last_i) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end else begin
          state_d   = ST_SHARE;
          cnt_inc_o = 1'b1;
        end
      end
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      settle_q <= '0;
      pos_q    <= 1'b0;
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;
      valid_q <= finish;
      if (state_q == ST_SETTLE) settle_q <= settle_q + 1'b1;
      else                      settle_q <= '0;
      if (state_q == ST_SGN_RD) pos_q <= dec_i;
      if (finish) begin
        // zero magnitude always reports positive
        result_q <= {(mag != '0) && !pos_q, mag};
      end
    end
  end

  assign toggle_o  = finish;
  assign cmp_en_o  = (state_q == ST_SGN_EN) || (state_q == ST_CMP_EN);
  assign share_o   = (state_q == ST_SHARE);
  assign busy_o    = (state_q != ST_IDLE);
  assign int_neg_o = pos_q;
  assign valid_o   = valid_q;
  assign result_o  = result_q;
endmodule

// File: rtl/serial_adc_ctrl.sv
module serial_adc_ctrl #(
  parameter int MAG_W      = 6,
  parameter int SETTLE_CYC = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           cmp_i,
  output logic           cmp_en_o,
  output logic           share_o,
  output logic           int_neg_o,
  output logic           swap_o,
  output logic           busy_o,
  output logic           valid_o,
  output logic [MAG_W:0] result_o
);
  logic             dec;
  logic             toggle;
  logic             cnt_clr;
  logic             cnt_inc;
  logic             cnt_last;
  logic [MAG_W-1:0] cnt;

  sadc_polarity u_pol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmp_raw_i(cmp_i),
    .toggle_i (toggle),
    .swap_o   (swap_o),
    .dec_o    (dec)
  );

  sadc_step_cnt #(.MAG_W(MAG_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt),
    .last_o(cnt_last)
  );

  sadc_fsm #(.MAG_W(MAG_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .dec_i     (dec),
    .cnt_i     (cnt),
    .cnt_last_i(cnt_last),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .toggle_o  (toggle),
    .cmp_en_o  (cmp_en_o),
    .share_o   (share_o),
    .busy_o    (busy_o),
    .int_neg_o (int_neg_o),
    .valid_o   (valid_o),
    .result_o  (result_o)
  );
endmodule

// File: rtl/sadc_checker.sv
module sadc_checker #(
  parameter int MAG_W = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cmp_en_o,
  input logic           share_o,
  input logic           swap_o,
  input logic           busy_o,
  input logic           valid_o,
  input logic [MAG_W:0] result_o
);
  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(share_o && cmp_en_o));

  a_r4_settle_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    share_o |=> (!cmp_en_o && !share_o));

  a_r4_sign_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (cmp_en_o && !share_o));

  a_r5_quiet_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (!cmp_en_o && !share_o && !busy_o));

  a_r7_swap_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (swap_o != $past(swap_o)));

  a_r7_swap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(swap_o));

  a_r8_zero_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (result_o[MAG_W-1:0] == '0)) |-> !result_o[MAG_W]);

  a_r9_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  a_r9_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));
endmodule

bind serial_adc_ctrl sadc_checker #(.MAG_W(MAG_W)) u_sadc_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cmp_en_o(cmp_en_o),
  .share_o (share_o),
  .swap_o  (swap_o),
  .busy_o  (busy_o),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/serial_adc_ctrl_tb_top.sv
module serial_adc_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAG_W      = 6;
  localparam int MAXM       = (2 ** MAG_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmp = 1'b0;
  logic cmp_en, share, int_neg, swap, busy, valid;
  logic [MAG_W:0] result;

  int checks = 0;
  int errors = 0;
  logic swap_exp = 1'b0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_adc_ctrl #(.MAG_W(MAG_W), .SETTLE_CYC(1)) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .cmp_i    (cmp),
    .cmp_en_o (cmp_en),
    .share_o  (share),
    .int_neg_o(int_neg),
    .swap_o   (swap),
    .busy_o   (busy),
    .valid_o  (valid),
    .result_o (result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // true comparison: positive rail at or above negative rail
  function automatic bit true_dec(input int x, input int steps);
    if (x >= 0) return x >= steps;
    return (x + steps) >= 0;
  endfunction

  function automatic int exp_mag(input int x);
    int m;
    m = (x >= 0) ? x : (-x - 1);
    return (m > MAXM) ? MAXM : m;
  endfunction

  function automatic int exp_res(input int x);
    int m;
    m = exp_mag(x);
    return (((x < 0) && (m != 0)) ? (1 << MAG_W) : 0) | m;
  endfunction

  task automatic convert(input int x, input bit poke_start);
    int shares = 0;
    int enables = 0;
    int cyc = 0;
    int exp_shares;
    bit got = 1'b0;
    bit after_sign = 1'b0;
    @(negedge clk);
    start = 1'b1;
    while (!got && cyc < 1000) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (poke_start && (cyc == 7 || cyc == 8)) start = 1'b1;
      if (share) begin
        shares++;
        after_sign = 1'b1;
        // R3: lower rail selection
        check(int_neg == (x >= 0), "R3", int_neg, (x >= 0));
      end
      if (cmp_en) begin
        enables++;
        cmp = true_dec(x, shares) ^ swap_exp;
        // R4: first enable is the bare sign compare
        if (enables == 1) check(!after_sign, "R4", shares, 0);
      end
      if (valid) begin
        got = 1'b1;
        swap_exp = ~swap_exp;
        check(result == exp_res(x), (x < 0) ? "R2" : "R5", result, exp_res(x));
        if (exp_mag(x) == MAXM) check(result[MAG_W-1:0] == MAXM, "R6", result[MAG_W-1:0], MAXM);
        if (exp_mag(x) == 0) check(result[MAG_W] == 1'b0, "R8", result[MAG_W], 0);
        check(swap == swap_exp, "R7", swap, swap_exp);
        exp_shares = (exp_mag(x) + 1 > MAXM) ? MAXM : exp_mag(x) + 1;
        check(shares == exp_shares, "R5", shares, exp_shares);
        check(enables == shares + 1, "R4", enables, shares + 1);
      end
    end
    start = 1'b0;
    if (!got) check(1'b0, "R9", 0, 1);
    @(negedge clk);
    check(!valid, "R9", valid, 0);
    check(result == exp_res(x), "R9", result, exp_res(x));
    if (poke_start) begin
      // R10: poke during busy must not launch another conversion
      check(!busy, "R10", busy, 0);
      @(negedge clk);
      check(!busy && !cmp_en, "R10", busy, 0);
    end
  endtask

  initial begin
    int seed;
    int x;
    seed = $urandom(32'h5AD_C0DE);
    repeat (3) @(negedge clk);
    check(!busy && !valid && !cmp_en && !share && !swap, "R1", {busy, valid, cmp_en, share, swap}, 0);
    check(result == 0, "R1", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !swap, "R1", {busy, swap}, 0);

    convert(0, 1'b0);
    convert(-1, 1'b0);
    convert(1, 1'b0);
    convert(-2, 1'b0);
    convert(62, 1'b0);
    convert(63, 1'b0);
    convert(70, 1'b0);
    convert(-64, 1'b0);
    convert(-63, 1'b0);
    convert(-70, 1'b0);
    convert(5, 1'b1);
    convert(-6, 1'b1);
    for (int i = 0; i < 40; i++) begin
      if ($urandom_range(1, 0) == 1) x = $urandom_range(16, 0) - 8;
      else x = $urandom_range(140, 0) - 70;
      convert(x, (i % 5) == 0);
    end
    done_flag = 1'b1;
  end

  initial begin
    int cnt = 0;
    while (!done_flag && cnt < 150000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done_flag) check(1'b0, "watchdog", cnt, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule